// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks the chain of extended capability headers kept in a configuration-space RAM and answers two kinds of request. A lookup names a 16-bit capability ID and returns the byte offset of the first header carrying that ID, together with the offset of the header that pointed to it. A lookup for the reserved ID 0 can never match, so it always runs to the end of the chain and reports the tail. That is the position at which a new capability is linked in.

An append request runs the tail walk itself and then links a new header at a caller-chosen offset. It rewrites the tail's next pointer and writes the new header with a null next pointer. When the new header is placed at the chain head (byte 0x100), the head's existing next pointer is carried into the new header, and nothing else is rewritten. The contents of a capability beyond its header word are not touched.

Requests are issued with a one-cycle `start` and complete with a one-cycle `done`. The block talks to the RAM through a single word-addressed port. Read data is taken one cycle after the read strobe.

Top module: `ecap_walker`

## Requirements
- R1: A header word holds the capability ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. Every walk begins by reading the word at byte offset 0x100 (word address 64).
- R2: If the head word is all zero, a lookup completes with found=0, err=0, res_off=0 and prev_off=0.
- R3: A lookup for a nonzero ID that matches a header completes with found=1, res_off set to that header's offset and prev_off set to the offset of the header before it (0 when the match is the head).
- R4: A lookup that reaches a header whose next pointer is 0 without a match completes with found=0, err=0, res_off=0 and prev_off set to the tail offset. ID 0 never matches, so it always reports the tail this way.
- R5: A nonzero next pointer is followed only if it is 4-byte aligned, at least 0x100 and at most 0xFF8. Otherwise the request ends with err=1, found=0, prev_off set to the offending header's offset, and no further read.
- R6: A walk visits at most MAX_NODES headers (default 960). A chain that is still going at that point ends with err=1 after exactly MAX_NODES reads.
- R7: An append at offset 0x100 reads the head and writes {old next, new version, new ID} back to 0x100. It makes exactly one write and completes with found=1, res_off=0x100, prev_off=0.
- R8: An append elsewhere walks to the tail and writes the tail header back with bits 31:20 set to the new offset and bits 19:0 kept. It then writes {0, version, ID} at the new offset, and completes with found=1, res_off set to the new offset and prev_off set to the tail offset.
- R9: An append is refused with err=1 and no RAM write if the offset is below 0x100, the offset is not 4-byte aligned, the size is 0, or offset+size is 4096 or more.
- R10: An append at an offset other than 0x100 on an empty chain (head word zero) ends with err=1 and no RAM write.
- R11: done is high for exactly one cycle per request. found, err, res_off and prev_off hold their values until the next request completes. A start while a request is in progress is ignored.
- R12: ram_rd and ram_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| op_append | input | 1 | 0 = lookup, 1 = append |
| cap_id | input | 16 | Capability ID to find or to write |
| cap_ver | input | 4 | Version for an appended header |
| new_off | input | 12 | Byte offset of the appended header |
| new_size | input | 12 | Byte size of the appended region |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Match found, or append written |
| err | output | 1 | Request ended on an error |
| res_off | output | 12 | Offset of the match or of the appended header |
| prev_off | output | 12 | Offset of the preceding header, or of the tail |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | 10 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid the cycle after ram_rd |

## Verification
The assertions assume a RAM that returns the word addressed by a read strobe on the following cycle and is not written by anyone else while a request runs. The bench's memory model meets this by construction. The bench edits the RAM only between requests, so the read window check and the stability of the held results depend only on the walker. Cyclic and out-of-window chains are built on purpose so that the guard and the bounds check are reached through legal port activity.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  // Header field layout; the next-pointer field is a byte offset.
  localparam int HDR_ID_W  = 16;
  localparam int HDR_VER_W = 4;
  localparam int HDR_NXT_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WTAIL,
    ST_WNEW,
    ST_DONE
  } walk_state_e;

  function automatic logic [HDR_ID_W-1:0] hdr_id(input logic [31:0] h);
    return h[15:0];
  endfunction

  function automatic logic [HDR_VER_W-1:0] hdr_ver(input logic [31:0] h);
    return h[19:16];
  endfunction

  function automatic logic [HDR_NXT_W-1:0] hdr_next(input logic [31:0] h);
    return h[31:20];
  endfunction

  function automatic logic [31:0] hdr_make(input logic [HDR_ID_W-1:0]  id,
                                           input logic [HDR_VER_W-1:0] ver,
                                           input logic [HDR_NXT_W-1:0] nxt);
    return {nxt, ver, id};
  endfunction

  // Replace only the next pointer of an existing header.
  function automatic logic [31:0] hdr_relink(input logic [31:0] h,
                                             input logic [HDR_NXT_W-1:0] nxt);
    return {nxt, hdr_ver(h), hdr_id(h)};
  endfunction

endpackage

// File: rtl/ecap_bounds.sv
module ecap_bounds #(
  parameter int CFG_BYTES = 4096,
  parameter int EXT_BASE  = 256,
  parameter int OFF_W     = 12
) (
  input  logic [OFF_W-1:0] nxt_off,
  input  logic [OFF_W-1:0] app_off,
  input  logic [OFF_W-1:0] app_size,
  output logic             nxt_ok,
  output logic             app_ok
);

  localparam logic [OFF_W:0] BASE_L = (OFF_W+1)'(EXT_BASE);
  localparam logic [OFF_W:0] TOP_L  = (OFF_W+1)'(CFG_BYTES - 8);
  localparam logic [OFF_W:0] CFG_L  = (OFF_W+1)'(CFG_BYTES);

  // A header may be visited if aligned and inside the extended window.
  function automatic logic visit_legal(input logic [OFF_W-1:0] off);
    logic [OFF_W:0] w;
    w = {1'b0, off};
    return (w >= BASE_L) && (w <= TOP_L) && (off[1:0] == 2'b00);
  endfunction

  // A new region must start in the window and end below the space size.
  function automatic logic region_legal(input logic [OFF_W-1:0] off,
                                        input logic [OFF_W-1:0] size);
    logic [OFF_W:0] fin;
    fin = {1'b0, off} + {1'b0, size};
    return ({1'b0, off} >= BASE_L) && (off[1:0] == 2'b00) &&
           (size != '0) && (fin < CFG_L);
  endfunction

  always_comb begin
    nxt_ok = visit_legal(nxt_off);
    app_ok = region_legal(app_off, app_size);
  end

endmodule

// File: rtl/ecap_node_ctr.sv
module ecap_node_ctr #(
  parameter int MAX_NODES = 960
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);

  localparam int CW = $clog2(MAX_NODES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_NODES);

  logic [CW-1:0] cnt;

  // The head read counts as the first visited node.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= CW'(1);
    else if (inc) cnt <= cnt + CW'(1);
  end

  assign at_limit = (cnt >= LIMIT);

  AST_CTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);  // R6
  AST_NO_STEP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit);  // R6

endmodule

// File: rtl/ecap_seq.sv
module ecap_seq
  import ecap_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int EXT_BASE  = 256,
  parameter int OFF_W     = 12,
  parameter int AW        = OFF_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_append,
  input  logic [15:0]      cap_id,
  input  logic [3:0]       cap_ver,
  input  logic [OFF_W-1:0] new_off,
  input  logic             app_ok,
  input  logic             nxt_ok,
  input  logic             at_limit,
  output logic [OFF_W-1:0] nxt_off,
  output logic             ctr_clr,
  output logic             ctr_inc,
  output logic             done,
  output logic             found,
  output logic             err,
  output logic [OFF_W-1:0] res_off,
  output logic [OFF_W-1:0] prev_off,
  output logic             ram_rd,
  output logic             ram_wr,
  output logic [AW-1:0]    ram_addr,
  output logic [31:0]      ram_wdata,
  input  logic [31:0]      ram_rdata
);

  localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(EXT_BASE);
  localparam logic [AW-1:0]    WIN_LO   = AW'(EXT_BASE / 4);
  localparam logic [AW-1:0]    WIN_HI   = AW'((CFG_BYTES - 8) / 4);

  walk_state_e state, state_nx;

  logic             req_app, req_head;
  logic [15:0]      req_id;
  logic [3:0]       req_ver;
  logic [OFF_W-1:0] req_new;
  logic [OFF_W-1:0] cur_off, prv_off;
  logic [31:0]      hold_hdr;

  // Named internal events
  logic ev_accept, ev_follow, ev_hit, ev_miss, ev_fault, ev_tail;
  logic empty_head, id_hit;
  logic fin, fin_found, fin_err;
  logic [OFF_W-1:0] fin_off, fin_prev;

  assign nxt_off    = OFF_W'(hdr_next(ram_rdata));
  assign empty_head = (cur_off == BASE_OFF) && (ram_rdata == 32'h0);
  assign id_hit     = !req_app && (req_id != 16'h0) && (hdr_id(ram_rdata) == req_id);
  assign ev_accept  = (state == ST_IDLE) && start;

  always_comb begin
    state_nx  = state;
    fin       = 1'b0;
    fin_found = 1'b0;
    fin_err   = 1'b0;
    fin_off   = '0;
    fin_prev  = '0;
    ev_follow = 1'b0;
    ev_hit    = 1'b0;
    ev_miss   = 1'b0;
    ev_fault  = 1'b0;
    ev_tail   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (op_append && !app_ok) begin
            fin      = 1'b1;
            fin_err  = 1'b1;
            ev_fault = 1'b1;
            state_nx = ST_DONE;
          end else begin
            state_nx = ST_READ;
          end
        end
      end
      ST_READ: state_nx = ST_CHECK;
      ST_CHECK: begin
        if (req_head) begin
          state_nx = ST_WNEW;
        end else if (empty_head) begin
          fin      = 1'b1;
          state_nx = ST_DONE;
          if (req_app) begin
            fin_err  = 1'b1;
            ev_fault = 1'b1;
          end else begin
            ev_miss = 1'b1;
          end
        end else if (id_hit) begin
          ev_hit    = 1'b1;
          fin       = 1'b1;
          fin_found = 1'b1;
          fin_off   = cur_off;
          fin_prev  = prv_off;
          state_nx  = ST_DONE;
        end else if (nxt_off == '0) begin
          if (req_app) begin
            ev_tail  = 1'b1;
            state_nx = ST_WTAIL;
          end else begin
            ev_miss  = 1'b1;
            fin      = 1'b1;
            fin_prev = cur_off;
            state_nx = ST_DONE;
          end
        end else if (!nxt_ok || at_limit) begin
          ev_fault = 1'b1;
          fin      = 1'b1;
          fin_err  = 1'b1;
          fin_prev = cur_off;
          state_nx = ST_DONE;
        end else begin
          ev_follow = 1'b1;
          state_nx  = ST_READ;
        end
      end
      ST_WTAIL: state_nx = ST_WNEW;
      ST_WNEW: begin
        fin       = 1'b1;
        fin_found = 1'b1;
        fin_off   = req_new;
        fin_prev  = req_head ? '0 : cur_off;
        state_nx  = ST_DONE;
      end
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_app  <= 1'b0;
      req_head <= 1'b0;
      req_id   <= '0;
      req_ver  <= '0;
      req_new  <= '0;
      cur_off  <= '0;
      prv_off  <= '0;
      hold_hdr <= '0;
      found    <= 1'b0;
      err      <= 1'b0;
      res_off  <= '0;
      prev_off <= '0;
    end else begin
      state <= state_nx;
      if (ev_accept) begin
        req_app  <= op_append;
        req_head <= op_append && (new_off == BASE_OFF);
        req_id   <= cap_id;
        req_ver  <= cap_ver;
        req_new  <= new_off;
        cur_off  <= BASE_OFF;
        prv_off  <= '0;
      end
      if (state == ST_CHECK) hold_hdr <= ram_rdata;
      if (ev_follow) begin
        prv_off <= cur_off;
        cur_off <= nxt_off;
      end
      if (fin) begin
        found    <= fin_found;
        err      <= fin_err;
        res_off  <= fin_off;
        prev_off <= fin_prev;
      end
    end
  end

  assign ctr_clr = ev_accept;
  assign ctr_inc = ev_follow;
  assign done    = (state == ST_DONE);
  assign ram_rd  = (state == ST_READ);
  assign ram_wr  = (state == ST_WTAIL) || (state == ST_WNEW);

  always_comb begin
    ram_addr  = cur_off[OFF_W-1:2];
    ram_wdata = hdr_relink(hold_hdr, HDR_NXT_W'(req_new));
    if (state == ST_WNEW) begin
      ram_addr  = req_new[OFF_W-1:2];
      ram_wdata = hdr_make(req_id, req_ver,
                           req_head ? hdr_next(hold_hdr) : '0);
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd && ram_wr));  // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R11
  AST_HIT_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(found && err));  // R5
  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |-> (ram_addr >= WIN_LO) && (ram_addr <= WIN_HI));  // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_off) && $stable(prev_off) && $stable(found) && $stable(err)));  // R11
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> !ram_wr);  // R9

endmodule

// File: rtl/ecap_walker.sv
module ecap_walker #(
  parameter int CFG_BYTES = 4096,
  parameter int EXT_BASE  = 256,
  parameter int MAX_NODES = 960,
  localparam int OFF_W    = $clog2(CFG_BYTES),
  localparam int AW       = OFF_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_append,
  input  logic [15:0]      cap_id,
  input  logic [3:0]       cap_ver,
  input  logic [OFF_W-1:0] new_off,
  input  logic [OFF_W-1:0] new_size,
  output logic             done,
  output logic             found,
  output logic             err,
  output logic [OFF_W-1:0] res_off,
  output logic [OFF_W-1:0] prev_off,
  output logic             ram_rd,
  output logic             ram_wr,
  output logic [AW-1:0]    ram_addr,
  output logic [31:0]      ram_wdata,
  input  logic [31:0]      ram_rdata
);

  logic [OFF_W-1:0] nxt_off;
  logic nxt_ok, app_ok, at_limit, ctr_clr, ctr_inc;

  ecap_bounds #(
    .CFG_BYTES(CFG_BYTES), .EXT_BASE(EXT_BASE), .OFF_W(OFF_W)
  ) u_bounds (
    .nxt_off (nxt_off),
    .app_off (new_off),
    .app_size(new_size),
    .nxt_ok  (nxt_ok),
    .app_ok  (app_ok)
  );

  ecap_node_ctr #(.MAX_NODES(MAX_NODES)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctr_clr),
    .inc     (ctr_inc),
    .at_limit(at_limit)
  );

  ecap_seq #(
    .CFG_BYTES(CFG_BYTES), .EXT_BASE(EXT_BASE), .OFF_W(OFF_W), .AW(AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_append(op_append),
    .cap_id   (cap_id),
    .cap_ver  (cap_ver),
    .new_off  (new_off),
    .app_ok   (app_ok),
    .nxt_ok   (nxt_ok),
    .at_limit (at_limit),
    .nxt_off  (nxt_off),
    .ctr_clr  (ctr_clr),
    .ctr_inc  (ctr_inc),
    .done     (done),
    .found    (found),
    .err      (err),
    .res_off  (res_off),
    .prev_off (prev_off),
    .ram_rd   (ram_rd),
    .ram_wr   (ram_wr),
    .ram_addr (ram_addr),
    .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

endmodule

// File: tb/test_ecap_walker.sv
module test_ecap_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_append = 1'b0;
  logic [15:0] cap_id = '0;
  logic [3:0]  cap_ver = '0;
  logic [11:0] new_off = '0, new_size = '0;
  logic        done, found, err, ram_rd, ram_wr;
  logic [11:0] res_off, prev_off;
  logic [9:0]  ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata = '0;

  always #2 clk = ~clk;  // 250 MHz

  ecap_walker i_ecap_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .op_append(op_append),
    .cap_id(cap_id), .cap_ver(cap_ver), .new_off(new_off), .new_size(new_size),
    .done(done), .found(found), .err(err), .res_off(res_off), .prev_off(prev_off),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // RAM model: one writer process for the array
  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;
  int rd_cnt = 0, wr_cnt = 0, both_cnt = 0;

  always @(posedge clk) begin
    if (ram_rd) ram_rdata <= mem[ram_addr];
    if (ram_wr) mem[ram_addr] <= ram_wdata;
    if (tb_we)  mem[tb_wa] <= tb_wd;
    if (ram_rd) rd_cnt++;
    if (ram_wr) wr_cnt++;
    if (ram_rd && ram_wr) both_cnt++;
  end

  int n_tests = 0, n_fail = 0;
  logic        r_found, r_err;
  logic [11:0] r_off, r_prev;
  int          r_rd, r_wr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] byte_off, input logic [31:0] d);
    tb_we = 1'b1; tb_wa = byte_off[11:2]; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_ram();
    for (int i = 0; i < 1024; i++) poke(12'(i * 4), 32'h0);
  endtask

  function automatic logic [31:0] hdr(input logic [11:0] nxt, input logic [3:0] v,
                                      input logic [15:0] id);
    return {nxt, v, id};
  endfunction

  task automatic run_op(input logic app, input logic [15:0] id, input logic [3:0] v,
                        input logic [11:0] off, input logic [11:0] sz);
    int rd0, wr0, t;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    start = 1'b1; op_append = app; cap_id = id; cap_ver = v; new_off = off; new_size = sz;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    r_found = found; r_err = err; r_off = res_off; r_prev = prev_off;
    r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
  endtask

  task automatic build_list();
    poke(12'h100, hdr(12'h140, 4'h1, 16'h0001));
    poke(12'h140, hdr(12'h200, 4'h2, 16'h000B));
    poke(12'h200, hdr(12'h000, 4'h1, 16'h0010));
  endtask

  task automatic t_reset();
    check("R11 reset done", done, 0);
    check("R11 reset found/err", {found, err}, 0);
    check("R12 reset strobes", {ram_rd, ram_wr}, 0);
  endtask

  task automatic t_empty();
    clear_ram();
    run_op(0, 16'h5, 0, 0, 0);
    check("R2 empty found/err", {r_found, r_err}, 0);
    check("R2 empty offsets", {r_off, r_prev}, 0);
    check("R1 head read count", r_rd, 1);
  endtask

  task automatic t_find();
    build_list();
    run_op(0, 16'h000B, 0, 0, 0);
    check("R3 mid hit", {r_found, r_err, r_off, r_prev}, {2'b10, 12'h140, 12'h100});
    run_op(0, 16'h0001, 0, 0, 0);
    check("R3 head hit", {r_found, r_off, r_prev}, {1'b1, 12'h100, 12'h000});
    run_op(0, 16'h0010, 0, 0, 0);
    check("R1 tail hit", {r_found, r_off, r_prev}, {1'b1, 12'h200, 12'h140});
    run_op(0, 16'h0077, 0, 0, 0);
    check("R4 miss", {r_found, r_err, r_off, r_prev}, {2'b00, 12'h000, 12'h200});
    run_op(0, 16'h0000, 0, 0, 0);
    check("R4 id0 tail", {r_found, r_err, r_off, r_prev}, {2'b00, 12'h000, 12'h200});
    check("R4 id0 reads", r_rd, 3);
  endtask

  task automatic t_append();
    run_op(1, 16'h000D, 4'h2, 12'h300, 12'h040);
    check("R8 result", {r_found, r_err, r_off, r_prev}, {2'b10, 12'h300, 12'h200});
    check("R8 tail relinked", mem[12'h200 >> 2], hdr(12'h300, 4'h1, 16'h0010));
    check("R8 new header", mem[12'h300 >> 2], hdr(12'h000, 4'h2, 16'h000D));
    check("R8 writes", r_wr, 2);
    run_op(0, 16'h000D, 0, 0, 0);
    check("R8 findable", {r_found, r_off, r_prev}, {1'b1, 12'h300, 12'h200});
  endtask

  task automatic t_reject();
    run_op(1, 16'h1, 1, 12'h080, 12'h010);
    check("R9 low offset", {r_err, r_found, 6'(r_wr)}, {2'b10, 6'd0});
    run_op(1, 16'h1, 1, 12'h302, 12'h010);
    check("R9 unaligned", {r_err, 6'(r_wr)}, {1'b1, 6'd0});
    run_op(1, 16'h1, 1, 12'hFC0, 12'h040);
    check("R9 end at 4096", {r_err, 6'(r_wr)}, {1'b1, 6'd0});
    run_op(1, 16'h1, 1, 12'hF00, 12'h000);
    check("R9 zero size", {r_err, 6'(r_wr), 6'(r_rd)}, {1'b1, 6'd0, 6'd0});
  endtask

  task automatic t_head_append();
    run_op(1, 16'h0022, 4'h3, 12'h100, 12'h010);
    check("R7 result", {r_found, r_err, r_off, r_prev}, {2'b10, 12'h100, 12'h000});
    check("R7 head word", mem[64], hdr(12'h140, 4'h3, 16'h0022));
    check("R7 one write", r_wr, 1);
  endtask

  task automatic t_bad_next();
    poke(12'h100, hdr(12'h0C0, 4'h1, 16'h1));
    run_op(0, 16'h5, 0, 0, 0);
    check("R5 below window", {r_err, r_found, r_prev}, {2'b10, 12'h100});
    check("R5 no further read", r_rd, 1);
    poke(12'h100, hdr(12'h102, 4'h1, 16'h1));
    run_op(0, 16'h5, 0, 0, 0);
    check("R5 unaligned next", {r_err, 6'(r_rd)}, {1'b1, 6'd1});
    poke(12'h100, hdr(12'hFFC, 4'h1, 16'h1));
    run_op(0, 16'h5, 0, 0, 0);
    check("R5 above window", {r_err, 6'(r_rd)}, {1'b1, 6'd1});
    poke(12'h100, hdr(12'hFF8, 4'h1, 16'h1));
    poke(12'hFF8, hdr(12'h000, 4'h1, 16'h5));
    run_op(0, 16'h5, 0, 0, 0);
    check("R5 top edge legal", {r_err, r_found, r_off, r_prev}, {2'b01, 12'hFF8, 12'h100});
  endtask

  task automatic t_cycle();
    poke(12'h100, hdr(12'h100, 4'h1, 16'h1));
    run_op(0, 16'h2, 0, 0, 0);
    check("R6 cycle err", {r_err, r_found}, 2'b10);
    check("R6 read count", r_rd, 960);
  endtask

  task automatic t_empty_append();
    poke(12'h100, 32'h0);
    run_op(1, 16'h9, 4'h1, 12'h200, 12'h010);
    check("R10 err", {r_err, r_found}, 2'b10);
    check("R10 no write", r_wr, 0);
  endtask

  task automatic t_busy();
    int t;
    clear_ram();
    build_list();
    @(negedge clk);
    start = 1'b1; op_append = 0; cap_id = 16'h0010;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; cap_id = 16'h0001;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    check("R11 busy start ignored", {found, res_off}, {1'b1, 12'h200});
    @(negedge clk);
    check("R11 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    check("R11 result held", {found, err, res_off, prev_off}, {2'b10, 12'h200, 12'h140});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_empty();
    t_find();
    t_append();
    t_reject();
    t_head_append();
    t_bad_next();
    t_cycle();
    t_empty_append();
    t_busy();
    check("R12 rd/wr overlap", both_cnt, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule